// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register core of a general-purpose I/O controller. Its pins are grouped into banks of 32. Software reaches them over a simple single-cycle register bus. Each register type is an array of 32-bit words, one word per bank, with a stride of four bytes. A pin's bank is its number divided by 32, and its bit within that word is its number modulo 32.

Software chooses per pin whether the pad is driven. It raises or lowers output levels through two separate write-one strobes, so a bit can change without a read-modify-write. It reads back the conditioned input level of every pin. Each input passes through a two-stage synchronizer. After that comes a glitch filter, which can be bypassed per pin.

Top module: `gpio_bank_regs`

## Requirements
- R1: Register word `bank` of a type sits at byte address base + 4·bank, and its bit k controls or reports pin 32·bank + k. Every bank from 0 to N_BANKS−1 is independent.
- R2: The level register (base 0x004) is read-only and returns the conditioned input level of each pin. A write to it changes no register and no pin output.
- R3: In the direction register (base 0x01C), a 1 bit drives `pin_oe_o` high for that pin (output) and a 0 bit leaves it an input. The register reads back as written.
- R4: A write to the set register (base 0x034) makes `pin_out_o` high for every 1 bit. The other output bits keep their values.
- R5: A write to the clear register (base 0x04C) makes `pin_out_o` low for every 1 bit. The other output bits keep their values.
- R6: A read of the set or clear register, of a misaligned address, or of any other unmapped address (including bank N_BANKS and above) returns zero. A write there changes nothing.
- R7: After a synchronous active-low reset, every register is zero. All pins are inputs, every output value is low and `rdata_o` is zero.
- R8: Inputs pass two synchronizer flops. With bypass set, a pin change made just before clock edge e becomes part of the level register after edge e+1.
- R9: With the filter enabled, a synchronized level change is accepted only after it has been present for 3 consecutive clocks. A pulse that is shorter never reaches the level register.
- R10: In the filter bypass register (base 0x094), a 1 bit bypasses the glitch filter for that pin and a 0 bit enables it. The register reads back as written.
- R11: `rdata_o` is registered. It loads the addressed value at the edge where `rd_en_i` is high and holds otherwise. A read and a write of the same address in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the register word |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| pin_in_i | input | 32·N_BANKS | Raw pad input levels |
| pin_out_o | output | 32·N_BANKS | Output values |
| pin_oe_o | output | 32·N_BANKS | Output enables (1 = driven) |

## Verification
A bus read and a bus write can fall in the same cycle. The bench drives both strobes in one cycle at the direction register's address. It then judges that `rdata_o` shows the old word and that a later read shows the new one. A pin change on the input side can also land in the same cycle as a read that is held on the level register. The bench steps edge by edge and judges the exact cycle in which the new level first shows, for both the bypassed path and the filtered path. It also checks that short pulses never show.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants and the register-kind type of the banked GPIO core.
// Assumes byte addressing with 32-bit register words.
package gpio_bank_pkg;
    localparam int BANK_BITS = 32;
    localparam int N_KINDS   = 5;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_LEVEL = 3'd1,
        K_DIR   = 3'd2,
        K_SET   = 3'd3,
        K_CLR   = 3'd4,
        K_BYP   = 3'd5
    } reg_kind_e;

    localparam int        KIND_BASE [N_KINDS] = '{32'h004, 32'h01C, 32'h034, 32'h04C, 32'h094};
    localparam reg_kind_e KIND_ID   [N_KINDS] = '{K_LEVEL, K_DIR, K_SET, K_CLR, K_BYP};
endpackage

// File: rtl/gpio_addr_decode.sv
// Module: turns a byte address into a register kind and a bank index.
// Assumes each kind is an array of N_BANKS words with a 4-byte stride, and
// that misaligned or out-of-range addresses decode to K_NONE.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int N_BANKS = 6,
    parameter int BANK_IW = 3
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output reg_kind_e          kind_o,
    output logic [BANK_IW-1:0] bank_o
);
    // Purpose: match the address against every kind's window.
    always_comb begin
        kind_o = K_NONE;
        bank_o = '0;
        for (int k = 0; k < N_KINDS; k++) begin
            int off;
            off = int'(addr_i) - KIND_BASE[k];
            if (off >= 0 && off < 4 * N_BANKS && (off % 4) == 0) begin
                kind_o = KIND_ID[k];
                bank_o = BANK_IW'(off / 4);
            end
        end
    end
endmodule

// File: rtl/gpio_in_filter.sv
// Module: one pin's input path, with a two-flop synchronizer and then a glitch filter.
// Assumes the filter accepts a level only after FILT_LEN consecutive
// synchronized samples of it. With bypass, the synchronizer output is used directly.
module gpio_in_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic bypass_i,
    output logic level_o
);
    localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic             s1_q, s2_q, filt_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: synchronize the pin, then qualify changes by a run-length count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            if (bypass_i) begin
                filt_q <= s2_q;
                cnt_q  <= '0;
            end else if (s2_q == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                filt_q <= s2_q;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = bypass_i ? s2_q : filt_q;

    // R9: with the filter on, the accepted level moves only when the run is complete
    a_r9_no_early_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && cnt_q != CNT_W'(FILT_LEN - 1)) |=> $stable(filt_q));
    // R8: in bypass, the filter state follows the synchronizer output
    a_r8_bypass_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |=> (filt_q == $past(s2_q)));
endmodule

// File: rtl/gpio_port_bank.sv
// Module: the writable state (direction, output value, filter bypass), one
// word of each per bank.
// Assumes set and clear arrive as separate bus writes, so they never meet in one cycle.
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int N_BANKS = 6,
    parameter int BANK_IW = 3,
    localparam int NPINS  = N_BANKS * BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  reg_kind_e            kind_i,
    input  logic [BANK_IW-1:0]   bank_i,
    input  logic [BANK_BITS-1:0] wdata_i,
    output logic [NPINS-1:0]     dir_o,
    output logic [NPINS-1:0]     out_o,
    output logic [NPINS-1:0]     byp_o
);
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [BANK_BITS-1:0] dir_q, out_q, byp_q;
        logic                 hit;

        assign hit = wr_en_i && (bank_i == BANK_IW'(b));

        // Purpose: apply bus writes aimed at this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dir_q <= '0;
                out_q <= '0;
                byp_q <= '0;
            end else if (hit) begin
                case (kind_i)
                    K_DIR:   dir_q <= wdata_i;
                    K_BYP:   byp_q <= wdata_i;
                    K_SET:   out_q <= out_q | wdata_i;
                    K_CLR:   out_q <= out_q & ~wdata_i;
                    default: ;
                endcase
            end
        end

        assign dir_o[b*BANK_BITS +: BANK_BITS] = dir_q;
        assign out_o[b*BANK_BITS +: BANK_BITS] = out_q;
        assign byp_o[b*BANK_BITS +: BANK_BITS] = byp_q;

        // R4: every 1 bit written to the set word ends up high
        a_r4_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && kind_i == K_SET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));
        // R5: every 1 bit written to the clear word ends up low
        a_r5_clr_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && kind_i == K_CLR) |=> ((out_q & $past(wdata_i)) == '0));
        // R4/R5: zero bits of a strobe leave the other outputs alone
        a_r4_r5_zero_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && (kind_i == K_SET || kind_i == K_CLR))
            |=> ((out_q & ~$past(wdata_i)) == ($past(out_q) & ~$past(wdata_i))));
    end
endmodule

// File: rtl/gpio_bank_regs.sv
// Module: top of the banked GPIO register file. It holds the bus decode, the read
// mux with its registered read data, the per-pin input conditioning and the state banks.
// Assumes a single-cycle bus. Read data appears the cycle after rd_en_i.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int N_BANKS  = 6,
    parameter int FILT_LEN = 3,
    localparam int NPINS   = N_BANKS * BANK_BITS,
    localparam int BANK_IW = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [BANK_BITS-1:0] wdata_i,
    input  logic                 rd_en_i,
    output logic [BANK_BITS-1:0] rdata_o,
    input  logic [NPINS-1:0]     pin_in_i,
    output logic [NPINS-1:0]     pin_out_o,
    output logic [NPINS-1:0]     pin_oe_o
);
    reg_kind_e            kind;
    logic [BANK_IW-1:0]   bank;
    logic [NPINS-1:0]     dir_vec, out_vec, byp_vec, level_vec;
    logic [BANK_BITS-1:0] rd_val;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .N_BANKS(N_BANKS), .BANK_IW(BANK_IW)) u_dec (
        .addr_i (addr_i),
        .kind_o (kind),
        .bank_o (bank)
    );

    gpio_port_bank #(.N_BANKS(N_BANKS), .BANK_IW(BANK_IW)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .kind_i  (kind),
        .bank_i  (bank),
        .wdata_i (wdata_i),
        .dir_o   (dir_vec),
        .out_o   (out_vec),
        .byp_o   (byp_vec)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_in_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_in_i[p]),
            .bypass_i (byp_vec[p]),
            .level_o  (level_vec[p])
        );
    end

    // Purpose: select the addressed readable word; write-only and unmapped read as zero.
    always_comb begin
        case (kind)
            K_LEVEL: rd_val = level_vec[int'(bank)*BANK_BITS +: BANK_BITS];
            K_DIR:   rd_val = dir_vec[int'(bank)*BANK_BITS +: BANK_BITS];
            K_BYP:   rd_val = byp_vec[int'(bank)*BANK_BITS +: BANK_BITS];
            default: rd_val = '0;
        endcase
    end

    // Purpose: register the read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_val;
    end

    assign pin_out_o = out_vec;
    assign pin_oe_o  = dir_vec;

    // R6: reads of write-only or unmapped words return zero
    a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (kind == K_NONE || kind == K_SET || kind == K_CLR)) |=> (rdata_o == '0));
    // R11: read data holds when no read is strobed
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));
    // R2: a write to the level word leaves the pin outputs alone
    a_r2_level_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && kind == K_LEVEL) |=> ($stable(pin_out_o) && $stable(pin_oe_o)));
    // R7: reset clears read data, output enables and output values
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (rdata_o == '0 && pin_oe_o == '0 && pin_out_o == '0));
endmodule

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
    localparam int N_BANKS = 6;
    localparam int NPINS   = N_BANKS * 32;
    localparam time TCLK   = 20ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       addr_i = '0;
    logic             wr_en_i = 1'b0;
    logic [31:0]      wdata_i = '0;
    logic             rd_en_i = 1'b0;
    logic [31:0]      rdata_o;
    logic [NPINS-1:0] pin_in_i = '0;
    logic [NPINS-1:0] pin_out_o;
    logic [NPINS-1:0] pin_oe_o;

    int n_chk = 0;
    int n_err = 0;

    gpio_bank_regs dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
        .pin_in_i(pin_in_i), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
    );

    always #(TCLK / 2) clk = ~clk;

    // vector: {is_read, req number, addr, data-or-expected}
    localparam int NV = 16;
    localparam logic [44:0] VEC [NV] = '{
        {1'b0, 4'd3,  8'h1C, 32'h0000_00FF},  // R3 dir bank0
        {1'b1, 4'd3,  8'h1C, 32'h0000_00FF},  // R3 readback
        {1'b0, 4'd4,  8'h38, 32'hF0F0_0001},  // R4 set bank1
        {1'b0, 4'd4,  8'h38, 32'h0000_0100},  // R4 set more
        {1'b0, 4'd5,  8'h50, 32'h0000_0001},  // R5 clear bank1
        {1'b1, 4'd6,  8'h38, 32'h0000_0000},  // R6 set reads zero
        {1'b1, 4'd6,  8'h50, 32'h0000_0000},  // R6 clear reads zero
        {1'b0, 4'd1,  8'h30, 32'h8000_0000},  // R1 dir bank5
        {1'b1, 4'd1,  8'h30, 32'h8000_0000},  // R1 readback bank5
        {1'b1, 4'd1,  8'h20, 32'h0000_0000},  // R1 bank1 untouched
        {1'b0, 4'd10, 8'h9C, 32'h1234_5678},  // R10 bypass bank2
        {1'b1, 4'd10, 8'h9C, 32'h1234_5678},  // R10 readback
        {1'b1, 4'd6,  8'hAC, 32'h0000_0000},  // R6 bank beyond range
        {1'b0, 4'd6,  8'h1D, 32'hFFFF_FFFF},  // R6 misaligned write
        {1'b1, 4'd6,  8'h1C, 32'h0000_00FF},  // R6 dir unaffected
        {1'b1, 4'd2,  8'h04, 32'h0000_0000}   // R2 level, inputs low
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    initial begin
        #(TCLK * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7 rdata", rdata_o, 32'h0);
        chk("R7 oe", 32'(pin_oe_o != '0), 32'h0);
        chk("R7 out", 32'(pin_out_o != '0), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(8'h1C, rv);
        chk("R7 dir reads zero", rv, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) begin
                bus_rd(VEC[i][39:32], rv);
                chk($sformatf("R%0d vector %0d", VEC[i][43:40], i), rv, VEC[i][31:0]);
            end else begin
                bus_wr(VEC[i][39:32], VEC[i][31:0]);
            end
        end
        bus_wr(8'h04, 32'hFFFF_FFFF);  // R2 write to level word
        chk("R4 R5 out bank1", pin_out_o[63:32], 32'hF0F0_0100);
        chk("R2 out bank0 unchanged", pin_out_o[31:0], 32'h0);
        chk("R3 oe bank0", pin_oe_o[31:0], 32'h0000_00FF);
        chk("R1 oe pin191", 32'(pin_oe_o[191]), 32'h1);

        // R11 read and write of one address in the same cycle
        addr_i = 8'h1C; wdata_i = 32'h0000_00A5; wr_en_i = 1'b1; rd_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        chk("R11 same-cycle read old", rdata_o, 32'h0000_00FF);
        @(negedge clk);
        chk("R11 hold without strobe", rdata_o, 32'h0000_00FF);
        bus_rd(8'h1C, rv);
        chk("R11 read new", rv, 32'h0000_00A5);

        // R8 bypassed pin 0: visible in rdata after third edge
        bus_wr(8'h94, 32'h0000_0001);
        addr_i = 8'h04; rd_en_i = 1'b1;
        @(negedge clk);
        pin_in_i[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 not yet after two edges", 32'(rdata_o[0]), 32'h0);
        @(negedge clk);
        chk("R8 visible after three edges", 32'(rdata_o[0]), 32'h1);

        // R9 filtered pin 1: accepted at edge 5, seen in rdata after edge 6
        pin_in_i[1] = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 filtered not yet", 32'(rdata_o[1]), 32'h0);
        @(negedge clk);
        chk("R9 filtered accepted", 32'(rdata_o[1]), 32'h1);

        // R9 two-cycle pulse on pin 2 is rejected
        pin_in_i[2] = 1'b1;
        repeat (2) @(negedge clk);
        pin_in_i[2] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R9 short pulse rejected", 32'(rdata_o[2]), 32'h0);
        end

        // R9 three-cycle pulse on pin 3 is accepted
        pin_in_i[3] = 1'b1;
        repeat (3) @(negedge clk);
        pin_in_i[3] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 three-cycle pulse accepted", 32'(rdata_o[3]), 32'h1);

        // R10 clearing bypass on pin 0 keeps its settled level
        rd_en_i = 1'b0;
        bus_wr(8'h94, 32'h0);
        bus_rd(8'h04, rv);
        chk("R10 filter re-enabled keeps level", 32'(rv[0]), 32'h1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule